// File: doc/BRIEF.md
# Shared-Mask Priority Ternary Lookup

This block is a small ternary match table. Every stored entry carries a key, a valid bit, a priority and a response. Each entry also carries the index of one slot in a compact table of shared masks. The mask table has far fewer slots than there are entries, so many entries reuse the same wildcard pattern. Only one mask word per slot is stored, not one per entry. A mask bit of 0 means the corresponding key bit is a don't-care.

A lookup key may be presented on every clock cycle. The key and each stored key are ANDed with that entry's mask and then compared. The result appears a fixed three cycles later. It carries a hit flag and the response of the matching entry whose priority value is numerically smallest. A simple write port loads either an entry or a mask slot, chosen by a select bit.

Top module: `tmask_lookup`

## Requirements
- R1: After reset every entry is invalid and `res_valid` is low, so every lookup issued before any entry is written misses.
- R2: A stored entry matches a lookup key when `(lookup_key & M) == (entry_key & M)`, where M is the mask slot that the entry refers to. Key bits where M is 0 have no influence on the match.
- R3: An entry written with `wr_entry_valid` = 0, or never written, never matches.
- R4: When several entries match, `res_resp` is the response of a matching entry whose priority value is the smallest among the matches.
- R5: When the smallest priority is shared by several matching entries, `res_resp` is the response of one of those tied entries.
- R6: When no entry matches, `res_hit` is 0 and `res_resp` is 0.
- R7: A lookup that is accepted (`lu_valid`=1) at a rising edge produces `res_valid`=1 exactly three rising edges later. Results keep request order and one lookup may be issued every cycle. `res_hit` is never high without `res_valid`.
- R8: A write and a lookup issued in the same cycle: the lookup sees the table contents before the write. A lookup issued in the following cycle sees the written contents.
- R9: Mask slots are numbered 0 to NUM_MASKS-1. An entry whose mask index is NUM_MASKS or above never matches. A mask-slot write to such an address has no effect.
- R10: Rewriting a mask slot changes the match behaviour of every valid entry that refers to that slot, for all lookups issued afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lu_valid | input | 1 | Lookup request strobe |
| lu_key | input | KEY_W | Lookup key |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | 0: write entry, 1: write mask slot |
| wr_addr | input | AW | Entry index, or mask slot index |
| wr_data | input | KEY_W | Entry key, or mask word for a slot write |
| wr_entry_valid | input | 1 | Valid bit stored with an entry write |
| wr_mask_idx | input | MIW | Mask slot that an entry refers to |
| wr_prio | input | PW | Entry priority (ignored when PRIO_W is 0) |
| wr_resp | input | RESP_W | Entry response |
| res_valid | output | 1 | Result strobe, three cycles after the request |
| res_hit | output | 1 | At least one valid entry matched |
| res_resp | output | RESP_W | Winning response, 0 on a miss |

## Verification
The two functions that can fall in the same cycle are a table write and a lookup. Either an entry write or a mask-slot write can be issued in the very cycle a lookup key is presented. The bench does this on purpose with a directed case: a higher-priority entry is written alongside a lookup it would win. Random traffic adds writes at random into a lookup stream that runs almost every cycle. A reference model evaluates each lookup against the model state before applying that cycle's write, so the old-contents rule is judged on every such collision.

// File: rtl/tml_pkg.sv
package tml_pkg;
   typedef enum logic {
      TML_WR_ENTRY = 1'b0,
      TML_WR_MASK  = 1'b1
   } tml_wr_sel_e;

   function automatic int tml_idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/tml_mask_bank.sv
module tml_mask_bank #(
   parameter int KEY_W     = 16,
   parameter int NUM_MASKS = 3,
   parameter int MIW       = 2,
   parameter int AW        = 4,
   localparam int MS       = 1 << MIW
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [AW-1:0]               wr_addr,
   input  logic [KEY_W-1:0]            wr_mask,
   output logic [MS-1:0][KEY_W-1:0]    masks,
   output logic [MS-1:0]               slot_live
);
   for (genvar s = 0; s < MS; s++) begin : g_slot
      if (s < NUM_MASKS) begin : g_real
         logic [KEY_W-1:0] word_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                 word_q <= '0;
            else if (wr_en && wr_addr == AW'(s))        word_q <= wr_mask;
         end
         assign masks[s]     = word_q;
         assign slot_live[s] = 1'b1;
      end else begin : g_absent
         assign masks[s]     = '0;
         assign slot_live[s] = 1'b0;
      end
   end
endmodule

// File: rtl/tml_entry_bank.sv
module tml_entry_bank #(
   parameter int KEY_W       = 16,
   parameter int RESP_W      = 8,
   parameter int PW          = 4,
   parameter int NUM_ENTRIES = 16,
   parameter int NUM_MASKS   = 3,
   parameter int MIW         = 2,
   parameter int AW          = 4,
   localparam int MS         = 1 << MIW
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [AW-1:0]                     wr_addr,
   input  logic                              wr_valid,
   input  logic [KEY_W-1:0]                  wr_key,
   input  logic [MIW-1:0]                    wr_midx,
   input  logic [PW-1:0]                     wr_prio,
   input  logic [RESP_W-1:0]                 wr_resp,
   input  logic [MS-1:0][KEY_W-1:0]          masks,
   input  logic [MS-1:0]                     slot_live,
   input  logic                              lu_valid,
   input  logic [KEY_W-1:0]                  lu_key,
   output logic                              lv_q,
   output logic [NUM_ENTRIES-1:0]            hit_q,
   output logic [NUM_ENTRIES-1:0][PW-1:0]    prio_q,
   output logic [NUM_ENTRIES-1:0][RESP_W-1:0] resp_q
);
   logic [NUM_ENTRIES-1:0]             e_valid;
   logic [NUM_ENTRIES-1:0][KEY_W-1:0]  e_key;
   logic [NUM_ENTRIES-1:0][MIW-1:0]    e_midx;
   logic [NUM_ENTRIES-1:0][PW-1:0]     e_prio;
   logic [NUM_ENTRIES-1:0][RESP_W-1:0] e_resp;
   logic [NUM_ENTRIES-1:0]             hit_c;

   for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            e_valid[i] <= 1'b0;
            e_key[i]   <= '0;
            e_midx[i]  <= '0;
            e_prio[i]  <= '0;
            e_resp[i]  <= '0;
         end else if (wr_en && wr_addr == AW'(i)) begin
            e_valid[i] <= wr_valid;
            e_key[i]   <= wr_key;
            e_midx[i]  <= wr_midx;
            e_prio[i]  <= wr_prio;
            e_resp[i]  <= wr_resp;
         end
      end

      // compare runs on pre-edge table state, so a same-cycle write is not seen
      assign hit_c[i] = lu_valid & e_valid[i] & slot_live[e_midx[i]] &
                        (((lu_key ^ e_key[i]) & masks[e_midx[i]]) == '0);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hit_q[i]  <= 1'b0;
            prio_q[i] <= '0;
            resp_q[i] <= '0;
         end else begin
            hit_q[i]  <= hit_c[i];
            prio_q[i] <= e_prio[i];
            resp_q[i] <= e_resp[i];
         end
      end

      AST_DEAD_ENTRY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         !e_valid[i] |=> !hit_q[i]); // R3

      if (NUM_MASKS < MS) begin : g_oob_chk
         AST_NO_SLOT_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
            (e_midx[i] >= MIW'(NUM_MASKS)) |=> !hit_q[i]); // R9
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lv_q <= 1'b0;
      else        lv_q <= lu_valid;
   end
endmodule

// File: rtl/tml_prio_pick.sv
module tml_prio_pick #(
   parameter int N      = 8,
   parameter int PW     = 4,
   parameter int RESP_W = 8
) (
   input  logic [N-1:0]             hit,
   input  logic [N-1:0][PW-1:0]     prio,
   input  logic [N-1:0][RESP_W-1:0] resp,
   output logic                     any,
   output logic [PW-1:0]            win_prio,
   output logic [RESP_W-1:0]        win_resp
);
   always_comb begin
      any      = 1'b0;
      win_prio = '0;
      win_resp = '0;
      for (int i = 0; i < N; i++) begin
         // strict compare: on a tie the lower index keeps the slot
         if (hit[i] && (!any || prio[i] < win_prio)) begin
            any      = 1'b1;
            win_prio = prio[i];
            win_resp = resp[i];
         end
      end
   end
endmodule

// File: rtl/tmask_lookup.sv
module tmask_lookup #(
   parameter int KEY_W       = 16,
   parameter int RESP_W      = 8,
   parameter int PRIO_W      = 4,
   parameter int NUM_ENTRIES = 16,
   parameter int NUM_MASKS   = 3,
   localparam int MIW        = tml_pkg::tml_idx_w(NUM_MASKS),
   localparam int EIW        = tml_pkg::tml_idx_w(NUM_ENTRIES),
   localparam int AW         = (EIW > MIW) ? EIW : MIW,
   localparam int PW         = (PRIO_W > 0) ? PRIO_W : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lu_valid,
   input  logic [KEY_W-1:0]  lu_key,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [AW-1:0]     wr_addr,
   input  logic [KEY_W-1:0]  wr_data,
   input  logic              wr_entry_valid,
   input  logic [MIW-1:0]    wr_mask_idx,
   input  logic [PW-1:0]     wr_prio,
   input  logic [RESP_W-1:0] wr_resp,
   output logic              res_valid,
   output logic              res_hit,
   output logic [RESP_W-1:0] res_resp
);
   import tml_pkg::*;

   localparam int MS = 1 << MIW;
   localparam int LO = NUM_ENTRIES / 2;
   localparam int HI = NUM_ENTRIES - LO;

   if (KEY_W < 1 || RESP_W < 1)  begin : g_bad_w   $error("widths must be positive");          end
   if (NUM_ENTRIES < 2)          begin : g_bad_n   $error("NUM_ENTRIES must be at least 2");   end
   if (NUM_MASKS < 1)            begin : g_bad_m   $error("NUM_MASKS must be at least 1");     end
   if (PRIO_W < 0 || PRIO_W > 32) begin : g_bad_p  $error("PRIO_W must lie in 0..32");        end

   logic [PW-1:0] prio_in;
   if (PRIO_W == 0) begin : g_noprio
      assign prio_in = '0;
   end else begin : g_prio
      assign prio_in = wr_prio;
   end

   logic mask_we, ent_we;
   assign mask_we = wr_en && (wr_sel == TML_WR_MASK);
   assign ent_we  = wr_en && (wr_sel == TML_WR_ENTRY);

   logic [MS-1:0][KEY_W-1:0] masks;
   logic [MS-1:0]            slot_live;

   tml_mask_bank #(.KEY_W(KEY_W), .NUM_MASKS(NUM_MASKS), .MIW(MIW), .AW(AW)) u_masks (
      .clk(clk), .rst_n(rst_n), .wr_en(mask_we), .wr_addr(wr_addr),
      .wr_mask(wr_data), .masks(masks), .slot_live(slot_live));

   logic                               s1_v;
   logic [NUM_ENTRIES-1:0]             s1_hit;
   logic [NUM_ENTRIES-1:0][PW-1:0]     s1_prio;
   logic [NUM_ENTRIES-1:0][RESP_W-1:0] s1_resp;

   tml_entry_bank #(.KEY_W(KEY_W), .RESP_W(RESP_W), .PW(PW), .NUM_ENTRIES(NUM_ENTRIES),
                    .NUM_MASKS(NUM_MASKS), .MIW(MIW), .AW(AW)) u_entries (
      .clk(clk), .rst_n(rst_n), .wr_en(ent_we), .wr_addr(wr_addr),
      .wr_valid(wr_entry_valid), .wr_key(wr_data), .wr_midx(wr_mask_idx),
      .wr_prio(prio_in), .wr_resp(wr_resp), .masks(masks), .slot_live(slot_live),
      .lu_valid(lu_valid), .lu_key(lu_key), .lv_q(s1_v), .hit_q(s1_hit),
      .prio_q(s1_prio), .resp_q(s1_resp));

   // stage 2: each half reduced to its own winner
   logic              lo_any, hi_any;
   logic [PW-1:0]     lo_prio, hi_prio;
   logic [RESP_W-1:0] lo_resp, hi_resp;

   tml_prio_pick #(.N(LO), .PW(PW), .RESP_W(RESP_W)) u_pick_lo (
      .hit(s1_hit[LO-1:0]), .prio(s1_prio[LO-1:0]), .resp(s1_resp[LO-1:0]),
      .any(lo_any), .win_prio(lo_prio), .win_resp(lo_resp));

   tml_prio_pick #(.N(HI), .PW(PW), .RESP_W(RESP_W)) u_pick_hi (
      .hit(s1_hit[NUM_ENTRIES-1:LO]), .prio(s1_prio[NUM_ENTRIES-1:LO]),
      .resp(s1_resp[NUM_ENTRIES-1:LO]),
      .any(hi_any), .win_prio(hi_prio), .win_resp(hi_resp));

   logic              s2_v, s2_lo_any, s2_hi_any;
   logic [PW-1:0]     s2_lo_prio, s2_hi_prio;
   logic [RESP_W-1:0] s2_lo_resp, s2_hi_resp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_v       <= 1'b0;
         s2_lo_any  <= 1'b0;
         s2_hi_any  <= 1'b0;
         s2_lo_prio <= '0;
         s2_hi_prio <= '0;
         s2_lo_resp <= '0;
         s2_hi_resp <= '0;
      end else begin
         s2_v       <= s1_v;
         s2_lo_any  <= lo_any;
         s2_hi_any  <= hi_any;
         s2_lo_prio <= lo_prio;
         s2_hi_prio <= hi_prio;
         s2_lo_resp <= lo_resp;
         s2_hi_resp <= hi_resp;
      end
   end

   // stage 3: final two-way decision
   logic take_hi;
   assign take_hi = s2_hi_any && (!s2_lo_any || s2_hi_prio < s2_lo_prio);

   logic [PW-1:0] res_prio_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid  <= 1'b0;
         res_hit    <= 1'b0;
         res_resp   <= '0;
         res_prio_q <= '0;
      end else begin
         res_valid  <= s2_v;
         res_hit    <= s2_lo_any | s2_hi_any;
         res_resp   <= take_hi ? s2_hi_resp : s2_lo_resp;
         res_prio_q <= take_hi ? s2_hi_prio : s2_lo_prio;
      end
   end

   logic [1:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd3) |-> (res_valid == $past(lu_valid, 3))); // R7
   AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      res_hit |-> res_valid); // R7
   AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_hit) |-> (res_resp == '0)); // R6
   AST_MIN_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (s2_lo_any && s2_hi_any) |=>
         (res_prio_q <= $past(s2_lo_prio)) && (res_prio_q <= $past(s2_hi_prio))); // R4
endmodule

// File: tb/tmask_lookup_test.sv
module tmask_lookup_test;
   localparam int KW = 16, RW = 8, PRW = 4, NE = 16, NM = 3;
   localparam int MIW = 2, AW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lu_valid = 1'b0;
   logic [KW-1:0] lu_key = '0;
   logic wr_en = 1'b0, wr_sel = 1'b0, wr_entry_valid = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [KW-1:0] wr_data = '0;
   logic [MIW-1:0] wr_mask_idx = '0;
   logic [PRW-1:0] wr_prio = '0;
   logic [RW-1:0] wr_resp = '0;
   logic res_valid, res_hit;
   logic [RW-1:0] res_resp;

   always #4 clk = ~clk;

   tmask_lookup #(.KEY_W(KW), .RESP_W(RW), .PRIO_W(PRW), .NUM_ENTRIES(NE), .NUM_MASKS(NM)) uut (
      .clk(clk), .rst_n(rst_n), .lu_valid(lu_valid), .lu_key(lu_key), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data), .wr_entry_valid(wr_entry_valid),
      .wr_mask_idx(wr_mask_idx), .wr_prio(wr_prio), .wr_resp(wr_resp),
      .res_valid(res_valid), .res_hit(res_hit), .res_resp(res_resp));

   int n_chk = 0, n_bad = 0, cyc = 0;
   bit done = 1'b0;

   // reference model
   bit            m_valid [NE];
   logic [KW-1:0] m_key   [NE];
   int            m_midx  [NE];
   int            m_prio  [NE];
   logic [RW-1:0] m_resp  [NE];
   logic [KW-1:0] m_mask  [NM];

   // expected results in flight, indexed by cycle modulo 4
   bit            r_v   [4];
   bit            r_hit [4];
   bit [NE-1:0]   r_ok  [4];
   logic [RW-1:0] r_snap[4][NE];
   string         r_tag [4];

   task automatic check(input bit cond, input string tag, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!cond) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic tick(input string tag, input bit lv, input logic [KW-1:0] k,
                       input bit we, input bit sel, input int addr, input logic [KW-1:0] d,
                       input bit ev, input int midx, input int pr, input int rs);
      int slot, wslot, best;
      bit found;
      @(negedge clk);
      slot = (cyc + 1) % 4;
      check(res_valid == r_v[slot], "R7", "res_valid", res_valid, r_v[slot]);
      if (r_v[slot]) begin
         check(res_hit == r_hit[slot], r_tag[slot], "res_hit", res_hit, r_hit[slot]);
         if (r_hit[slot]) begin
            found = 1'b0;
            best = 0;
            for (int i = NE - 1; i >= 0; i--)
               if (r_ok[slot][i]) begin
                  best = i;
                  if (res_resp == r_snap[slot][i]) found = 1'b1;
               end
            check(found, r_tag[slot], "res_resp", res_resp, r_snap[slot][best]);
         end else begin
            check(res_resp == '0, "R6", "res_resp on miss", res_resp, 0);
         end
      end
      // model result using table state before this cycle's write (R8)
      wslot = cyc % 4;
      r_v[wslot] = lv;
      r_tag[wslot] = tag;
      r_hit[wslot] = 1'b0;
      r_ok[wslot] = '0;
      best = 1 << 30;
      for (int i = 0; i < NE; i++) begin
         r_snap[wslot][i] = m_resp[i];
         if (m_valid[i] && m_midx[i] < NM &&
             ((k & m_mask[m_midx[i]]) == (m_key[i] & m_mask[m_midx[i]]))) begin
            r_hit[wslot] = lv;
            if (m_prio[i] < best) begin best = m_prio[i]; r_ok[wslot] = '0; end
            if (m_prio[i] == best) r_ok[wslot][i] = 1'b1;
         end
      end
      lu_valid = lv;
      lu_key = k;
      wr_en = we;
      wr_sel = sel;
      wr_addr = AW'(addr);
      wr_data = d;
      wr_entry_valid = ev;
      wr_mask_idx = MIW'(midx);
      wr_prio = PRW'(pr);
      wr_resp = RW'(rs);
      if (we) begin
         if (sel) begin
            if (addr < NM) m_mask[addr] = d;
         end else begin
            m_valid[addr] = ev; m_key[addr] = d; m_midx[addr] = midx;
            m_prio[addr] = pr;  m_resp[addr] = RW'(rs);
         end
      end
      cyc++;
   endtask

   task automatic look(input string tag, input logic [KW-1:0] k);
      tick(tag, 1'b1, k, 1'b0, 1'b0, 0, '0, 1'b0, 0, 0, 0);
   endtask
   task automatic put_mask(input string tag, input int a, input logic [KW-1:0] m);
      tick(tag, 1'b0, '0, 1'b1, 1'b1, a, m, 1'b0, 0, 0, 0);
   endtask
   task automatic put_ent(input string tag, input int a, input logic [KW-1:0] k,
                          input bit ev, input int mi, input int pr, input int rs);
      tick(tag, 1'b0, '0, 1'b1, 1'b0, a, k, ev, mi, pr, rs);
   endtask
   task automatic idle(input int n);
      for (int i = 0; i < n; i++) tick("R7", 1'b0, '0, 1'b0, 1'b0, 0, '0, 1'b0, 0, 0, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      for (int i = 0; i < NE; i++) begin
         m_valid[i] = 0; m_key[i] = '0; m_midx[i] = 0; m_prio[i] = 0; m_resp[i] = '0;
      end
      for (int i = 0; i < NM; i++) m_mask[i] = '0;
      for (int i = 0; i < 4; i++) begin r_v[i] = 0; r_tag[i] = "R1"; r_hit[i] = 0; r_ok[i] = '0; end
      repeat (3) @(negedge clk);
      check(res_valid == 1'b0, "R1", "res_valid in reset", res_valid, 0);
      rst_n = 1'b1;
      // R1: empty table misses
      look("R1", 16'h0000);
      look("R1", 16'hFFFF);
      idle(3);
      // R2: ignored key bits
      put_mask("R2", 0, 16'hFF00);
      put_ent("R2", 0, 16'h12AB, 1'b1, 0, 5, 8'h11);
      look("R2", 16'h1234);
      look("R6", 16'h1334);
      // R8: same-cycle write sees old contents, next lookup sees new (also R4)
      tick("R8", 1'b1, 16'h12FF, 1'b1, 1'b0, 1, 16'h1200, 1'b1, 0, 2, 8'h22);
      look("R8", 16'h12FF);
      look("R4", 16'h1200);
      // R3: invalidated entry stops matching
      put_ent("R3", 1, 16'h1200, 1'b0, 0, 2, 8'h22);
      look("R3", 16'h12FF);
      // R5: tie on priority 5
      put_mask("R5", 1, 16'hF000);
      put_ent("R5", 2, 16'h1000, 1'b1, 1, 5, 8'h33);
      look("R5", 16'h12AA);
      // R9: reference to an unimplemented slot, and write to it ignored
      put_mask("R9", 3, 16'h0000);
      put_ent("R9", 3, 16'h0000, 1'b1, 3, 0, 8'h44);
      look("R9", 16'h5555);
      // R10: rewrite shared slot 0 to all-wildcard
      put_mask("R10", 0, 16'h0000);
      look("R10", 16'h5555);
      look("R10", 16'hABCD);
      idle(3);
      // constrained random traffic, lookups nearly every cycle
      seed = 32'h5EED;
      void'($urandom(seed));
      for (int i = 0; i < NE; i++) put_ent("R4", i, '0, 1'b0, 0, 0, 0);
      for (int i = 0; i < NM; i++) put_mask("R2", i, 16'($urandom) | 16'hF000);
      for (int t = 0; t < 3000; t++) begin
         bit lv, we, sel;
         int a, src;
         logic [KW-1:0] k;
         lv = ($urandom % 8) != 0;
         we = ($urandom % 6) == 0;
         sel = ($urandom % 5) == 0;
         src = $urandom % NE;
         k = m_key[src] ^ (16'($urandom) & ~16'hF000 & (($urandom % 2) ? 16'h0FFF : 16'h000F));
         a = sel ? ($urandom % 4) : ($urandom % NE);
         tick("R4", lv, k, we, sel, a,
              sel ? (16'($urandom) | 16'hF000) : 16'($urandom),
              ($urandom % 4) != 0, $urandom % 4, $urandom % 16, $urandom % 256);
      end
      idle(4);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule